// File: doc/BRIEF.md
# Fused Multiply-Add Special-Case Resolver

This combinational block sits in front of a single-precision fused multiply-add datapath that computes `z + x*y`. It receives the three raw operand encodings, two negation controls and the current rounding mode. It classifies each operand itself, into zero, normal, denormal, infinity, quiet NaN or signalling NaN. It then decides whether the final result follows from the operand classes alone.

When the result follows from the classes, the block drives the finished 32-bit result and asserts `bypass`. It also raises `invalid` where the operation is invalid. When the operands are finite and the product is nonzero, `bypass` stays low and the main arithmetic datapath must produce the result. Rounding and arithmetic are outside this block.

Top module: `fma_special_resolve`

## Requirements
- R1: If any operand is a signalling NaN (exponent all ones, nonzero fraction, fraction bit 22 clear), the first one in the order z, x, y is returned with fraction bit 22 set, and `invalid`=1 and `bypass`=1.
- R2: With no signalling NaN present, the first quiet NaN (exponent all ones, fraction bit 22 set) in the order z, x, y is returned bit-for-bit, with `invalid`=0 and `bypass`=1.
- R3: With no NaN present, infinity times zero (either operand order) returns 0x7FC00000 with `invalid`=1 and `bypass`=1.
- R4: With an infinite product, an infinite z whose effective sign differs from the product sign gives 0x7FC00000 with `invalid`=1.
- R5: Any other infinite product returns an infinity (exponent all ones, fraction zero) whose sign bit is the product sign, with `invalid`=0.
- R6: With a zero or finite product and an infinite z, the result is infinity with the effective sign of z and `invalid`=0.
- R7: With a zero product and a zero z, equal signs give a zero of that sign. Unequal signs give +0 (0x00000000), except when `rnd_mode`=2'b11 (toward minus infinity), which gives -0 (0x80000000).
- R8: With a zero product and a nonzero finite z, the result is z's magnitude bits with the effective sign of z in bit 31.
- R9: The product sign is x[31] XOR y[31], inverted when `neg_prod`=1. The effective sign of z is z[31], inverted when `neg_addend`=1.
- R10: When both x and y are normal or denormal and z is finite, `bypass`=0, `invalid`=0 and `result`=0.
- R11: Classification uses bits [30:23] as the exponent and bits [22:0] as the fraction. An exponent of zero gives zero (fraction zero) or denormal. An all-ones exponent gives infinity (fraction zero), quiet NaN or signalling NaN. Any other exponent gives normal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_z | input | 32 | Addend encoding |
| op_x | input | 32 | First multiplicand encoding |
| op_y | input | 32 | Second multiplicand encoding |
| neg_prod | input | 1 | Invert the product sign |
| neg_addend | input | 1 | Invert the addend sign |
| rnd_mode | input | 2 | Rounding mode: 00 nearest, 01 toward zero, 10 toward +inf, 11 toward -inf |
| result | output | 32 | Resolved result; zero when not bypassed |
| invalid | output | 1 | Invalid-operation flag |
| bypass | output | 1 | Result resolved without arithmetic |

## Verification
The bench sweeps every triple drawn from a set of sign and class representatives, under every combination of negation controls and rounding modes. It compares each result against its own reference written from the requirements. It targets NaN precedence: a resolver with the wrong priority returns the x or y NaN where the z NaN is expected, or leaves a signalling NaN unquieted. It also targets the opposite-sign zero sum under each rounding mode, where a faulty design returns +0 under round-toward-minus-infinity. Directed checks probe the classification boundaries: the largest signalling and smallest quiet fraction, and a negated infinite addend that cancels or matches the product sign.

// File: rtl/fma_sr_pkg.sv
package fma_sr_pkg;

  typedef enum logic [2:0] {
    CL_ZERO = 3'd0,
    CL_NORM = 3'd1,
    CL_DNRM = 3'd2,
    CL_INF  = 3'd3,
    CL_QNAN = 3'd4,
    CL_SNAN = 3'd5
  } fclass_e;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } rmode_e;

  localparam int unsigned NUM_OPS = 3;
  localparam int unsigned IDX_Z   = 0;
  localparam int unsigned IDX_X   = 1;
  localparam int unsigned IDX_Y   = 2;

endpackage

// File: rtl/fma_sr_classify.sv
module fma_sr_classify
  import fma_sr_pkg::*;
#(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] bits_in,
  output fclass_e              cls,
  output logic                 sign
);

  localparam int unsigned W = 1 + EXP_W + MAN_W;

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             exp_ones;
  logic             exp_zero;
  logic             man_zero;

  assign sign     = bits_in[W-1];
  assign exp_f    = bits_in[W-2:MAN_W];
  assign man_f    = bits_in[MAN_W-1:0];
  assign exp_ones = &exp_f;
  assign exp_zero = ~|exp_f;
  assign man_zero = ~|man_f;

  always_comb begin
    if (exp_zero) begin
      cls = man_zero ? CL_ZERO : CL_DNRM;
    end else if (exp_ones) begin
      if (man_zero) begin
        cls = CL_INF;
      end else if (man_f[MAN_W-1]) begin
        cls = CL_QNAN;
      end else begin
        cls = CL_SNAN;
      end
    end else begin
      cls = CL_NORM;
    end
  end

endmodule

// File: rtl/fma_sr_nan_pick.sv
module fma_sr_nan_pick
  import fma_sr_pkg::*;
#(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23
) (
  input  fclass_e [NUM_OPS-1:0]             cls,
  input  logic    [NUM_OPS-1:0][EXP_W+MAN_W:0] raw,
  output logic                              hit,
  output logic    [EXP_W+MAN_W:0]           val,
  output logic                              inv
);

  localparam int unsigned W = 1 + EXP_W + MAN_W;
  localparam logic [W-1:0] QUIET_BIT = W'(1) << (MAN_W - 1);

  // Later assignments win: descending index scan gives z the highest
  // priority, and the signalling pass overrides the quiet pass.
  always_comb begin
    hit = 1'b0;
    val = '0;
    inv = 1'b0;
    for (int i = NUM_OPS - 1; i >= 0; i--) begin
      if (cls[i] == CL_QNAN) begin
        hit = 1'b1;
        val = raw[i];
      end
    end
    for (int i = NUM_OPS - 1; i >= 0; i--) begin
      if (cls[i] == CL_SNAN) begin
        hit = 1'b1;
        val = raw[i] | QUIET_BIT;
        inv = 1'b1;
      end
    end
  end

endmodule

// File: rtl/fma_sr_special.sv
module fma_sr_special
  import fma_sr_pkg::*;
#(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23
) (
  input  fclass_e              cls_x,
  input  fclass_e              cls_y,
  input  fclass_e              cls_z,
  input  logic                 sign_x,
  input  logic                 sign_y,
  input  logic                 sign_z,
  input  logic                 neg_prod,
  input  logic                 neg_addend,
  input  rmode_e               rm,
  input  logic [EXP_W+MAN_W:0] z_raw,
  output logic                 hit,
  output logic [EXP_W+MAN_W:0] val,
  output logic                 inv
);

  localparam int unsigned W = 1 + EXP_W + MAN_W;
  localparam logic [W-2:0] INF_MAG  = {{EXP_W{1'b1}}, {MAN_W{1'b0}}};
  localparam logic [W-1:0] DFLT_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic ps, zs;
  logic x_inf, y_inf, x_zero, y_zero, z_inf, z_zero;
  logic prod_inf, prod_zero, inf_times_zero;

  assign ps = sign_x ^ sign_y ^ neg_prod;
  assign zs = sign_z ^ neg_addend;

  assign x_inf  = (cls_x == CL_INF);
  assign y_inf  = (cls_y == CL_INF);
  assign x_zero = (cls_x == CL_ZERO);
  assign y_zero = (cls_y == CL_ZERO);
  assign z_inf  = (cls_z == CL_INF);
  assign z_zero = (cls_z == CL_ZERO);

  assign inf_times_zero = (x_inf & y_zero) | (x_zero & y_inf);
  assign prod_inf       = (x_inf | y_inf) & ~inf_times_zero;
  assign prod_zero      = (x_zero | y_zero) & ~inf_times_zero;

  always_comb begin
    hit = 1'b1;
    inv = 1'b0;
    val = '0;
    if (inf_times_zero) begin
      inv = 1'b1;
      val = DFLT_NAN;
    end else if (prod_inf) begin
      if (z_inf && (zs != ps)) begin
        inv = 1'b1;
        val = DFLT_NAN;
      end else begin
        val = {ps, INF_MAG};
      end
    end else if (z_inf) begin
      val = {zs, INF_MAG};
    end else if (prod_zero) begin
      if (z_zero) begin
        if (zs == ps) begin
          val = {zs, {(W-1){1'b0}}};
        end else begin
          val = {(rm == RM_DOWN), {(W-1){1'b0}}};
        end
      end else begin
        val = {zs, z_raw[W-2:0]};
      end
    end else begin
      hit = 1'b0;
    end
  end

endmodule

// File: rtl/fma_special_resolve.sv
module fma_special_resolve
  import fma_sr_pkg::*;
#(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] op_z,
  input  logic [EXP_W+MAN_W:0] op_x,
  input  logic [EXP_W+MAN_W:0] op_y,
  input  logic                 neg_prod,
  input  logic                 neg_addend,
  input  logic [1:0]           rnd_mode,
  output logic [EXP_W+MAN_W:0] result,
  output logic                 invalid,
  output logic                 bypass
);

  localparam int unsigned W = 1 + EXP_W + MAN_W;

  logic    [NUM_OPS-1:0][W-1:0] opnd;
  fclass_e [NUM_OPS-1:0]        cls;
  logic    [NUM_OPS-1:0]        sgn;

  logic         nan_hit, nan_inv;
  logic [W-1:0] nan_val;
  logic         sp_hit, sp_inv;
  logic [W-1:0] sp_val;
  rmode_e       rm;

  assign opnd[IDX_Z] = op_z;
  assign opnd[IDX_X] = op_x;
  assign opnd[IDX_Y] = op_y;
  assign rm          = rmode_e'(rnd_mode);

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_cls
    fma_sr_classify #(
      .EXP_W(EXP_W),
      .MAN_W(MAN_W)
    ) i_cls (
      .bits_in(opnd[g]),
      .cls    (cls[g]),
      .sign   (sgn[g])
    );
  end

  fma_sr_nan_pick #(
    .EXP_W(EXP_W),
    .MAN_W(MAN_W)
  ) i_nan (
    .cls(cls),
    .raw(opnd),
    .hit(nan_hit),
    .val(nan_val),
    .inv(nan_inv)
  );

  fma_sr_special #(
    .EXP_W(EXP_W),
    .MAN_W(MAN_W)
  ) i_spc (
    .cls_x     (cls[IDX_X]),
    .cls_y     (cls[IDX_Y]),
    .cls_z     (cls[IDX_Z]),
    .sign_x    (sgn[IDX_X]),
    .sign_y    (sgn[IDX_Y]),
    .sign_z    (sgn[IDX_Z]),
    .neg_prod  (neg_prod),
    .neg_addend(neg_addend),
    .rm        (rm),
    .z_raw     (op_z),
    .hit       (sp_hit),
    .val       (sp_val),
    .inv       (sp_inv)
  );

  always_comb begin
    if (nan_hit) begin
      result  = nan_val;
      invalid = nan_inv;
      bypass  = 1'b1;
    end else if (sp_hit) begin
      result  = sp_val;
      invalid = sp_inv;
      bypass  = 1'b1;
    end else begin
      result  = '0;
      invalid = 1'b0;
      bypass  = 1'b0;
    end
  end

endmodule

// File: rtl/fma_special_resolve_chk.sv
module fma_special_resolve_chk #(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23
) (
  input logic [EXP_W+MAN_W:0] op_z,
  input logic [EXP_W+MAN_W:0] op_x,
  input logic [EXP_W+MAN_W:0] op_y,
  input logic                 neg_prod,
  input logic                 neg_addend,
  input logic [1:0]           rnd_mode,
  input logic [EXP_W+MAN_W:0] result,
  input logic                 invalid,
  input logic                 bypass
);

  localparam int unsigned W = 1 + EXP_W + MAN_W;

  function automatic logic is_nan(input logic [W-1:0] v);
    return (&v[W-2:MAN_W]) && (|v[MAN_W-1:0]);
  endfunction

  function automatic logic is_snan(input logic [W-1:0] v);
    return is_nan(v) && !v[MAN_W-1];
  endfunction

  logic any_nan, any_snan, all_zero;

  assign any_nan  = is_nan(op_z) | is_nan(op_x) | is_nan(op_y);
  assign any_snan = is_snan(op_z) | is_snan(op_x) | is_snan(op_y);
  assign all_zero = ~|{op_z[W-2:0], op_x[W-2:0], op_y[W-2:0]};

  always_comb begin
    if (invalid) begin
      assert_invalid_bypass_R3: assert (bypass)
        else $error("invalid raised without bypass");
    end
    if (!bypass) begin
      assert_idle_quiet_R10: assert (!invalid && result == '0)
        else $error("datapath case drives flags or result");
    end
    if (bypass && is_nan(result)) begin
      assert_quiet_out_R1: assert (result[MAN_W-1])
        else $error("signalling NaN leaked to the output");
    end
    if (any_snan) begin
      assert_snan_invalid_R1: assert (invalid && bypass)
        else $error("signalling operand without invalid");
    end
    if (all_zero && !any_nan) begin
      assert_zero_sum_R7: assert (bypass && result[W-2:0] == '0 &&
                                  (result[W-1] == ((op_z[W-1] ^ neg_addend) &
                                   (op_x[W-1] ^ op_y[W-1] ^ neg_prod)) ||
                                   ((op_z[W-1] ^ neg_addend) != (op_x[W-1] ^ op_y[W-1] ^ neg_prod))))
        else $error("zero sum not a zero");
    end
    if (!any_nan && (rnd_mode != 2'b11) && bypass && result[W-2:0] == '0 &&
        ((op_z[W-1] ^ neg_addend) != (op_x[W-1] ^ op_y[W-1] ^ neg_prod)) && all_zero) begin
      assert_pos_zero_R7: assert (!result[W-1])
        else $error("opposite zero sum not +0");
    end
  end

endmodule

bind fma_special_resolve fma_special_resolve_chk #(
  .EXP_W(EXP_W),
  .MAN_W(MAN_W)
) i_chk (
  .op_z      (op_z),
  .op_x      (op_x),
  .op_y      (op_y),
  .neg_prod  (neg_prod),
  .neg_addend(neg_addend),
  .rnd_mode  (rnd_mode),
  .result    (result),
  .invalid   (invalid),
  .bypass    (bypass)
);

// File: tb/test_fma_special_resolve.sv
module test_fma_special_resolve;

  logic        clk;
  logic        rst_n;
  logic [31:0] op_z, op_x, op_y;
  logic        neg_prod, neg_addend;
  logic [1:0]  rnd_mode;
  logic [31:0] result;
  logic        invalid, bypass;

  int checks;
  int errors;
  int cycles;
  bit done;

  fma_special_resolve i_fma_special_resolve (
    .op_z      (op_z),
    .op_x      (op_x),
    .op_y      (op_y),
    .neg_prod  (neg_prod),
    .neg_addend(neg_addend),
    .rnd_mode  (rnd_mode),
    .result    (result),
    .invalid   (invalid),
    .bypass    (bypass)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  localparam logic [31:0] DNAN = 32'h7FC0_0000;

  function automatic bit b_nan(input logic [31:0] v);
    return (v[30:23] == 8'hFF) && (v[22:0] != 0);
  endfunction
  function automatic bit b_snan(input logic [31:0] v);
    return b_nan(v) && (v[22] == 1'b0);
  endfunction
  function automatic bit b_inf(input logic [31:0] v);
    return (v[30:23] == 8'hFF) && (v[22:0] == 0);
  endfunction
  function automatic bit b_zero(input logic [31:0] v);
    return v[30:0] == 0;
  endfunction

  task automatic model(input logic [31:0] z, x, y, input logic np, na,
                       input logic [1:0] rm, output logic [31:0] r,
                       output logic inv, output logic byp, output string tag);
    logic ps, zs;
    ps  = x[31] ^ y[31] ^ np;
    zs  = z[31] ^ na;
    r   = 32'h0;
    inv = 1'b0;
    byp = 1'b1;
    if (b_snan(z))      begin r = z | 32'h0040_0000; inv = 1; tag = "R1"; end
    else if (b_snan(x)) begin r = x | 32'h0040_0000; inv = 1; tag = "R1"; end
    else if (b_snan(y)) begin r = y | 32'h0040_0000; inv = 1; tag = "R1"; end
    else if (b_nan(z))  begin r = z; tag = "R2"; end
    else if (b_nan(x))  begin r = x; tag = "R2"; end
    else if (b_nan(y))  begin r = y; tag = "R2"; end
    else if ((b_inf(x) && b_zero(y)) || (b_zero(x) && b_inf(y))) begin
      r = DNAN; inv = 1; tag = "R3";
    end else if (b_inf(x) || b_inf(y)) begin
      if (b_inf(z) && zs != ps) begin r = DNAN; inv = 1; tag = "R4"; end
      else begin r = {ps, 31'h7F80_0000}; tag = "R5"; end
    end else if (b_inf(z)) begin
      r = {zs, 31'h7F80_0000}; tag = "R6";
    end else if (b_zero(x) || b_zero(y)) begin
      if (b_zero(z)) begin
        r = (zs == ps) ? {zs, 31'h0} : {(rm == 2'b11), 31'h0};
        tag = "R7";
      end else begin
        r = {zs, z[30:0]}; tag = "R8";
      end
    end else begin
      byp = 1'b0; tag = "R10";
    end
  endtask

  task automatic apply_check(input logic [31:0] z, x, y, input logic np, na,
                             input logic [1:0] rm, input string note);
    logic [31:0] er;
    logic ei, eb;
    string tag;
    @(posedge clk);
    op_z = z; op_x = x; op_y = y;
    neg_prod = np; neg_addend = na; rnd_mode = rm;
    #5;
    model(z, x, y, np, na, rm, er, ei, eb, tag);
    checks++;
    if (result !== er || invalid !== ei || bypass !== eb) begin
      errors++;
      $display("FAIL %s%s z=%h x=%h y=%h np=%0d na=%0d rm=%0d got r=%h i=%0d b=%0d exp r=%h i=%0d b=%0d",
               tag, note, z, x, y, np, na, rm, result, invalid, bypass, er, ei, eb);
    end
  endtask

  logic [31:0] pats [12];

  initial begin
    pats[0]  = 32'h0000_0000; pats[1]  = 32'h8000_0000;
    pats[2]  = 32'h3F80_0000; pats[3]  = 32'hC020_0000;
    pats[4]  = 32'h0000_0001; pats[5]  = 32'h8040_0000;
    pats[6]  = 32'h7F80_0000; pats[7]  = 32'hFF80_0000;
    pats[8]  = 32'h7FC0_0001; pats[9]  = 32'hFFC1_2345;
    pats[10] = 32'h7F80_0001; pats[11] = 32'hFF81_2345;
    checks = 0; errors = 0; done = 0;
    op_z = '0; op_x = '0; op_y = '0;
    neg_prod = 0; neg_addend = 0; rnd_mode = 2'b00;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Initial state: all-zero operands give +0 bypass (R7)
    apply_check(32'h0, 32'h0, 32'h0, 0, 0, 2'b00, " initial");
    // Directed: classification boundaries (R11)
    apply_check(32'h7FBF_FFFF, 32'h3F80_0000, 32'h0, 0, 0, 2'b00, " R11 largest snan fraction");
    apply_check(32'h3F80_0000, 32'h7FC0_0000, 32'h7F80_0001, 0, 0, 2'b00, " R11 smallest qnan vs snan");
    apply_check(32'h007F_FFFF, 32'h0, 32'h0080_0000, 0, 0, 2'b00, " R11 max denormal z");
    apply_check(32'h7F7F_FFFF, 32'h0, 32'h3F80_0000, 0, 1, 2'b00, " R11 max normal z");
    // Directed: negation controls (R9)
    apply_check(32'hFF80_0000, 32'h7F80_0000, 32'h3F80_0000, 0, 1, 2'b00, " R9 negated addend matches");
    apply_check(32'h7F80_0000, 32'h7F80_0000, 32'h3F80_0000, 1, 0, 2'b00, " R9 negated product cancels");
    apply_check(32'h0, 32'h0, 32'h3F80_0000, 1, 0, 2'b11, " R9 zero sum round down");
    apply_check(32'h0, 32'h0, 32'h3F80_0000, 1, 1, 2'b11, " R9 both negated");
    // Sweep (R1..R10)
    for (int iz = 0; iz < 12; iz++)
      for (int ix = 0; ix < 12; ix++)
        for (int iy = 0; iy < 12; iy++)
          for (int c = 0; c < 16; c++)
            apply_check(pats[iz], pats[ix], pats[iy], c[0], c[1], c[3:2], "");
    done = 1;
  end

  initial begin
    cycles = 0;
    while (!done && cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule